// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block takes stereo PCM from a three-wire serial audio link (bit clock, frame clock, data) and presents each frame as a pair of parallel words with a one-cycle strobe. The framing is chosen by a static input: the standard inter-IC sound format, left-justified, right-justified, or a burst format where a one-bit sync pulse precedes two back-to-back words. The word length is also chosen statically: 16, 18, 20 or 24 bits.

The block runs on a single system clock `clk`, which also serves as the master clock. In slave mode the external bit clock and frame clock are synchronised into `clk` and the rising edges of the bit clock are detected there. Each bit-clock level must therefore last at least two `clk` cycles. In master mode the block divides `clk` to generate both clocks and drives them out. The same capture path then samples the data against these generated clocks, so the two modes share one deframer.

Captured words are MSB-aligned in 24-bit outputs. The bits below the word are zero.

Top module: `audio_serial_rx`

## Requirements
- R1: While `rst_n` is low, and after its release, `left_out` and `right_out` are zero and `frame_valid` is low. Asserting `rst_n` low clears the outputs at once.
- R2: With `cfg_fmt`=0 (inter-IC sound), the MSB is on the second bit-clock rising edge after a frame-clock change. The left word is sent while the frame clock is low.
- R3: With `cfg_fmt`=1 (left-justified), the MSB is on the first bit-clock rising edge after a frame-clock change. The left word is sent while the frame clock is high.
- R4: With `cfg_fmt`=2 (right-justified), the LSB is on the last bit-clock rising edge before the next frame-clock change. The left word is sent while the frame clock is high.
- R5: With `cfg_fmt`=3 (burst), the frame starts at a rising edge where the frame clock is sampled high after being low. The left MSB follows on the next rising edge, and the right word follows the left LSB with no gap.
- R6: `cfg_wlen` selects the word length: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24. The word appears in bits 23 downward, the lower bits are zero, and serial bits outside the word have no effect.
- R7: `frame_valid` is high for exactly one cycle once the right word of a frame is captured. It presents both words together, and the outputs change only in that cycle. A right word with no left word captured since the last strobe gives no strobe.
- R8: With `cfg_master`=1, `bclk_out` is `clk` divided by 4: two cycles high and two cycles low.
- R9: With `cfg_master`=1, a frame is 64 bit clocks long and `lrclk_out` changes only in the cycle where `bclk_out` falls. In the non-burst formats each level lasts 32 bit clocks. In burst format `lrclk_out` is high for one bit clock at the start of each frame.
- R10: With `cfg_master`=0, `bclk_out` and `lrclk_out` stay low. Data and frame clock are sampled on rising edges of `bclk_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fmt | input | 2 | Framing: 0 inter-IC sound, 1 left-justified, 2 right-justified, 3 burst |
| cfg_wlen | input | 2 | Word length code: 16/18/20/24 bits |
| cfg_master | input | 1 | 1 generates the clocks, 0 accepts external clocks |
| bclk_in | input | 1 | External bit clock (slave) |
| lrclk_in | input | 1 | External frame clock (slave) |
| sdata_in | input | 1 | Serial audio data |
| bclk_out | output | 1 | Generated bit clock (master) |
| lrclk_out | output | 1 | Generated frame clock (master) |
| left_out | output | 24 | Left sample, MSB-aligned |
| right_out | output | 24 | Right sample, MSB-aligned |
| frame_valid | output | 1 | One-cycle strobe for a new sample pair |

## Verification
The embedded assertions watch, on every cycle, several properties. They check that the strobe never lasts two cycles, that the sample outputs move only together with the strobe, and that the bits below the word are zero. They check that bit-clock events are never adjacent. They check that the generated bit clock holds high for two cycles, that the generated frame clock changes only on a bit-clock fall, and that both clocks stay quiet in slave mode. Only the bench scenarios can show that each framing puts the right serial bit into the right output position. The same holds for the channel polarity of each format, padding bits that are ignored, the measured clock ratios, and the suppression of a strobe for a lone right word.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  localparam int MAX_W = 24;
  localparam int WB_W  = $clog2(MAX_W + 1);

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_DSP = 2'd3
  } fmt_e;

  function automatic logic [WB_W-1:0] word_bits(input logic [1:0] code);
    case (code)
      2'd0:    return WB_W'(16);
      2'd1:    return WB_W'(18);
      2'd2:    return WB_W'(20);
      default: return WB_W'(24);
    endcase
  endfunction
endpackage

// File: rtl/aud_rx_clkgen.sv
module aud_rx_clkgen
  import aud_rx_pkg::*;
#(
  parameter int DIV_LOG2  = 2,
  parameter int HALF_LOG2 = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_master,
  input  fmt_e cfg_fmt,
  output logic bclk_o,
  output logic lr_o
);
  localparam int CW = DIV_LOG2 + HALF_LOG2 + 1;

  logic [CW-1:0] cnt_q, cnt_n;
  logic          lr_q, lr_n;

  always_comb begin
    cnt_n = cfg_master ? cnt_q + CW'(1) : '0;
    if (!cfg_master) begin
      lr_n = 1'b0;
    end else begin
      case (cfg_fmt)
        FMT_DSP: lr_n = (cnt_n[CW-1:DIV_LOG2] == '0);
        FMT_I2S: lr_n = cnt_n[CW-1];
        default: lr_n = ~cnt_n[CW-1];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lr_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      lr_q  <= lr_n;
    end
  end

  assign bclk_o = cnt_q[DIV_LOG2-1];
  assign lr_o   = lr_q;

  // R8
  bclk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && $rose(bclk_o)) |=> bclk_o);

  // R9
  lr_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && $past(cfg_master) && cnt_q != CW'(1) && lr_q != $past(lr_q))
      |-> $fell(bclk_o));

  // R10
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_master && !$past(cfg_master)) |-> (!bclk_o && !lr_o));
endmodule

// File: rtl/aud_rx_insync.sv
module aud_rx_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_master,
  input  logic bclk_gen,
  input  logic lr_gen,
  input  logic bclk_ext,
  input  logic lr_ext,
  input  logic sd_ext,
  output logic bit_evt,
  output logic lr_s,
  output logic sd_s
);
  logic [STAGES:0]   bclk_q, bclk_n;
  logic [STAGES-1:0] lr_q, lr_n;
  logic [STAGES-1:0] sd_q, sd_n;
  logic              bclk_src, lr_src;

  always_comb begin
    bclk_src = cfg_master ? bclk_gen : bclk_ext;
    lr_src   = cfg_master ? lr_gen   : lr_ext;
    bclk_n   = {bclk_q[STAGES-1:0], bclk_src};
    lr_n     = {lr_q[STAGES-2:0], lr_src};
    sd_n     = {sd_q[STAGES-2:0], sd_ext};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= '0;
      lr_q   <= '0;
      sd_q   <= '0;
    end else begin
      bclk_q <= bclk_n;
      lr_q   <= lr_n;
      sd_q   <= sd_n;
    end
  end

  assign bit_evt = bclk_q[STAGES-1] & ~bclk_q[STAGES];
  assign lr_s    = lr_q[STAGES-1];
  assign sd_s    = sd_q[STAGES-1];

  // R10
  evt_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_evt |=> !bit_evt);
endmodule

// File: rtl/aud_rx_deframer.sv
module aud_rx_deframer
  import aud_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  fmt_e              cfg_fmt,
  input  logic [1:0]        cfg_wlen,
  input  logic              bit_evt,
  input  logic              lr_s,
  input  logic              sd_s,
  output logic [MAX_W-1:0]  left_out,
  output logic [MAX_W-1:0]  right_out,
  output logic              frame_valid
);
  localparam int IDX_W = $clog2(2 * MAX_W + 1) + 1;
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic             lr_prev_q, lr_prev_n;
  logic [IDX_W-1:0] idx_q, idx_n, idx_cur;
  logic [MAX_W-1:0] sh_q, sh_n, with_d, src, mask, aligned;
  logic [MAX_W-1:0] hold_q, hold_n, left_q, left_n, right_q, right_n;
  logic             have_left_q, have_left_n, valid_q, valid_n;
  logic [WB_W-1:0]  wbits, pad_sh;
  logic [IDX_W-1:0] w_idx, w2_idx;
  logic             trans, cap, cap_left;

  always_comb begin
    wbits   = word_bits(cfg_wlen);
    pad_sh  = WB_W'(MAX_W) - wbits;
    w_idx   = IDX_W'(wbits);
    w2_idx  = IDX_W'({wbits, 1'b0});
    mask    = ~({MAX_W{1'b1}} << wbits);
    trans   = (cfg_fmt == FMT_DSP) ? (lr_s & ~lr_prev_q) : (lr_s ^ lr_prev_q);
    idx_cur = trans ? '0 : ((idx_q == IDX_MAX) ? idx_q : idx_q + IDX_W'(1));
    with_d  = {sh_q[MAX_W-2:0], sd_s};

    case (cfg_fmt)
      FMT_I2S: begin
        cap = (idx_cur == w_idx);  cap_left = ~lr_s;      src = with_d;
      end
      FMT_LJ: begin
        cap = (idx_cur == w_idx - IDX_W'(1)); cap_left = lr_s; src = with_d;
      end
      FMT_RJ: begin
        cap = trans;               cap_left = lr_prev_q;  src = sh_q;
      end
      default: begin
        cap = (idx_cur == w_idx) || (idx_cur == w2_idx);
        cap_left = (idx_cur == w_idx);
        src = with_d;
      end
    endcase
    cap     = cap & bit_evt;
    aligned = (src & mask) << pad_sh;

    lr_prev_n   = lr_prev_q;
    idx_n       = idx_q;
    sh_n        = sh_q;
    hold_n      = hold_q;
    have_left_n = have_left_q;
    left_n      = left_q;
    right_n     = right_q;
    valid_n     = 1'b0;

    if (bit_evt) begin
      lr_prev_n = lr_s;
      idx_n     = idx_cur;
      sh_n      = with_d;
    end
    if (cap && cap_left) begin
      hold_n      = aligned;
      have_left_n = 1'b1;
    end
    if (cap && !cap_left && have_left_q) begin
      left_n      = hold_q;
      right_n     = aligned;
      valid_n     = 1'b1;
      have_left_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_prev_q   <= 1'b0;
      idx_q       <= '0;
      sh_q        <= '0;
      hold_q      <= '0;
      have_left_q <= 1'b0;
      left_q      <= '0;
      right_q     <= '0;
      valid_q     <= 1'b0;
    end else begin
      lr_prev_q   <= lr_prev_n;
      idx_q       <= idx_n;
      sh_q        <= sh_n;
      hold_q      <= hold_n;
      have_left_q <= have_left_n;
      left_q      <= left_n;
      right_q     <= right_n;
      valid_q     <= valid_n;
    end
  end

  assign left_out    = left_q;
  assign right_out   = right_q;
  assign frame_valid = valid_q;

  // R7
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  // R7
  out_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (left_out != $past(left_out) || right_out != $past(right_out)) |-> frame_valid);

  // R6
  low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> (((left_out | right_out) & ~({MAX_W{1'b1}} << pad_sh)) == '0));
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int DIV_LOG2    = 2,
  parameter int HALF_LOG2   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_fmt,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_master,
  input  logic              bclk_in,
  input  logic              lrclk_in,
  input  logic              sdata_in,
  output logic              bclk_out,
  output logic              lrclk_out,
  output logic [MAX_W-1:0]  left_out,
  output logic [MAX_W-1:0]  right_out,
  output logic              frame_valid
);
  fmt_e fmt;
  logic bclk_gen, lr_gen, bit_evt, lr_s, sd_s;

  assign fmt = fmt_e'(cfg_fmt);

  aud_rx_clkgen #(.DIV_LOG2(DIV_LOG2), .HALF_LOG2(HALF_LOG2)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_fmt(fmt),
    .bclk_o(bclk_gen), .lr_o(lr_gen)
  );

  aud_rx_insync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master),
    .bclk_gen(bclk_gen), .lr_gen(lr_gen),
    .bclk_ext(bclk_in), .lr_ext(lrclk_in), .sd_ext(sdata_in),
    .bit_evt(bit_evt), .lr_s(lr_s), .sd_s(sd_s)
  );

  aud_rx_deframer u_deframe (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(fmt), .cfg_wlen(cfg_wlen),
    .bit_evt(bit_evt), .lr_s(lr_s), .sd_s(sd_s),
    .left_out(left_out), .right_out(right_out), .frame_valid(frame_valid)
  );

  assign bclk_out  = bclk_gen;
  assign lrclk_out = lr_gen;
endmodule

// File: tb/audio_serial_rx_tb.sv
`timescale 1ns/1ps
module audio_serial_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_fmt, cfg_wlen;
  logic        cfg_master, bclk_in, lrclk_in, sdata_in;
  logic        bclk_out, lrclk_out, frame_valid;
  logic [23:0] left_out, right_out;

  int checks = 0;
  int fails  = 0;
  int strb_cnt = 0;
  logic [23:0] last_l, last_r;

  always #10 clk = ~clk;

  audio_serial_rx dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen),
    .cfg_master(cfg_master), .bclk_in(bclk_in), .lrclk_in(lrclk_in),
    .sdata_in(sdata_in), .bclk_out(bclk_out), .lrclk_out(lrclk_out),
    .left_out(left_out), .right_out(right_out), .frame_valid(frame_valid)
  );

  always @(negedge clk) begin
    if (rst_n && frame_valid) begin
      strb_cnt = strb_cnt + 1;
      last_l   = left_out;
      last_r   = right_out;
    end
  end

  // fields: fmt, wlen code, master, pad bit, left, right
  localparam int NV = 12;
  localparam logic [53:0] VECS [NV] = '{
    {2'd0, 2'd3, 1'b0, 1'b0, 24'hA5C3E1, 24'h1F2E3D},
    {2'd0, 2'd0, 1'b0, 1'b1, 24'hFFABCD, 24'h771234},
    {2'd1, 2'd2, 1'b0, 1'b1, 24'h08F0F1, 24'h0A5A5A},
    {2'd1, 2'd3, 1'b1, 1'b0, 24'h800001, 24'h7FFFFE},
    {2'd2, 2'd0, 1'b0, 1'b1, 24'h12C0DE, 24'h34BEEF},
    {2'd2, 2'd3, 1'b1, 1'b0, 24'hC0FFEE, 24'h0BADF0},
    {2'd2, 2'd1, 1'b0, 1'b0, 24'h02AAAA, 24'h015555},
    {2'd3, 2'd3, 1'b0, 1'b1, 24'h123456, 24'h89ABCD},
    {2'd3, 2'd0, 1'b1, 1'b0, 24'h00F00F, 24'h009669},
    {2'd0, 2'd2, 1'b1, 1'b1, 24'h0DCBA9, 24'h012345},
    {2'd1, 2'd1, 1'b1, 1'b1, 24'h03C3C3, 24'h024681},
    {2'd3, 2'd2, 1'b0, 1'b0, 24'h0E1E2E, 24'h0F0F0F}
  };

  function automatic int wbits(input logic [1:0] c);
    case (c) 2'd0: return 16; 2'd1: return 18; 2'd2: return 20; default: return 24; endcase
  endfunction

  function automatic logic lr_at(input logic [1:0] f, input int pos);
    case (f)
      2'd0:    return pos >= 32;
      2'd3:    return pos == 0;
      default: return pos < 32;
    endcase
  endfunction

  function automatic logic d_at(input logic [1:0] f, input int wb, input logic pad,
                                input logic [23:0] l, input logic [23:0] r, input int pos);
    int k;
    logic [23:0] w;
    k = pos % 32;
    w = (pos >= 32) ? r : l;
    case (f)
      2'd0: return (k >= 1 && k <= wb) ? w[wb-k] : pad;
      2'd1: return (k < wb) ? w[wb-1-k] : pad;
      2'd2: return (k >= 32 - wb) ? w[31-k] : pad;
      default: begin
        if (pos >= 1 && pos <= wb) return l[wb-pos];
        if (pos > wb && pos <= 2*wb) return r[2*wb-pos];
        return pad;
      end
    endcase
  endfunction

  function automatic string fmt_req(input logic [1:0] f);
    case (f) 2'd0: return "R2"; 2'd1: return "R3"; 2'd2: return "R4"; default: return "R5"; endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] f, input logic [1:0] wl, input logic m);
    @(negedge clk);
    rst_n = 1'b0; cfg_fmt = f; cfg_wlen = wl; cfg_master = m;
    bclk_in = 1'b0; lrclk_in = 1'b0; sdata_in = 1'b0;
    repeat (3) @(negedge clk);
    strb_cnt = 0;
    rst_n = 1'b1;
  endtask

  task automatic send_edge(input logic lr, input logic d);
    @(negedge clk);
    bclk_in = 1'b0; lrclk_in = lr; sdata_in = d;
    repeat (3) @(negedge clk);
    bclk_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_bclk_rise();
    logic pb;
    pb = bclk_out;
    forever begin
      @(negedge clk);
      if (!pb && bclk_out) break;
      pb = bclk_out;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    rst_n = 1'b0; cfg_fmt = 2'd0; cfg_wlen = 2'd3; cfg_master = 1'b0;
    bclk_in = 1'b0; lrclk_in = 1'b0; sdata_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(left_out == 0 && right_out == 0 && !frame_valid, "R1", "reset outputs",
        {left_out, right_out}, 48'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(left_out == 0 && right_out == 0 && !frame_valid, "R1", "after release",
        {left_out, right_out}, 48'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  f, wl;
      logic        m, pad;
      logic [23:0] l, r, el, er, msk;
      int          wb;
      {f, wl, m, pad, l, r} = VECS[i];
      wb  = wbits(wl);
      msk = ~(24'hFFFFFF << wb);
      el  = (l & msk) << (24 - wb);
      er  = (r & msk) << (24 - wb);
      do_reset(f, wl, m);
      if (!m) begin
        for (int k = 0; k < 4; k++) send_edge(lr_at(f, 63), 1'b0);
        for (int p = 0; p < 64; p++) send_edge(lr_at(f, p), d_at(f, wb, pad, l, r, p));
        for (int p = 0; p < 3; p++) send_edge(lr_at(f, p), 1'b0);
        repeat (8) @(negedge clk);
        chk(strb_cnt == 1, "R7", $sformatf("vec %0d strobe count", i), 48'(strb_cnt), 48'd1);
        // R10 clocks stay low in slave mode
        chk(!bclk_out && !lrclk_out, "R10", "slave outputs quiet",
            {46'd0, bclk_out, lrclk_out}, 48'd0);
      end else begin
        int  p;
        logic pb;
        p = 0; pb = 1'b0;
        sdata_in = d_at(f, wb, pad, l, r, 0);
        while (p < 132) begin
          @(negedge clk);
          if (pb && !bclk_out) begin
            p++;
            sdata_in = d_at(f, wb, pad, l, r, p % 64);
          end
          pb = bclk_out;
        end
        repeat (8) @(negedge clk);
        chk(strb_cnt >= 1, "R7", $sformatf("vec %0d master strobe seen", i),
            48'(strb_cnt), 48'd1);
      end
      // R6 word length alignment, checked per framing
      chk(last_l == el && last_r == er, fmt_req(f),
          $sformatf("vec %0d R6 words (fmt %0d wlen %0d)", i, f, wb),
          {last_l, last_r}, {el, er});
    end

    // R1 reset asserted mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(left_out == 0 && right_out == 0 && !frame_valid, "R1", "mid-run reset",
        {left_out, right_out}, 48'h0);

    // R8 bit clock divide
    begin
      int hi, lo;
      do_reset(2'd0, 2'd3, 1'b1);
      wait_bclk_rise();
      hi = 1; lo = 0;
      while (bclk_out) begin @(negedge clk); if (bclk_out) hi++; end
      lo = 1;
      @(negedge clk);
      while (!bclk_out) begin lo++; @(negedge clk); end
      chk(hi == 2 && lo == 2, "R8", "bclk high/low cycles", 48'({hi[7:0], lo[7:0]}), 48'h0202);
    end

    // R9 frame clock: 32 bit clocks per level, changes with bclk fall
    begin
      logic plr, pbk;
      int   cyc, rises, toggles;
      bit   fall_ok;
      plr = lrclk_out; pbk = bclk_out; cyc = 0; rises = 0; toggles = 0; fall_ok = 1;
      while (toggles < 3) begin
        @(negedge clk);
        cyc++;
        if (!pbk && bclk_out) rises++;
        if (lrclk_out != plr) begin
          if (!(pbk && !bclk_out)) fall_ok = 0;
          if (toggles > 0)
            chk(rises == 32 && cyc == 128, "R9", "level length in bclks",
                48'(rises), 48'd32);
          toggles++; rises = 0; cyc = 0;
        end
        plr = lrclk_out; pbk = bclk_out;
      end
      chk(fall_ok, "R9", "frame clock moves on bclk fall", 48'(fall_ok), 48'd1);
    end

    // R9 burst format sync pulse in master mode
    begin
      int hi, per;
      do_reset(2'd3, 2'd3, 1'b1);
      while (!lrclk_out) @(negedge clk);
      while (lrclk_out) @(negedge clk);
      while (!lrclk_out) @(negedge clk);
      hi = 0; per = 0;
      while (lrclk_out) begin hi++; per++; @(negedge clk); end
      while (!lrclk_out) begin per++; @(negedge clk); end
      chk(hi == 4, "R9", "burst sync width", 48'(hi), 48'd4);
      chk(per == 256, "R9", "burst frame period", 48'(per), 48'd256);
    end

    // R7 lone right word yields no strobe
    do_reset(2'd0, 2'd0, 1'b0);
    for (int k = 0; k < 40; k++) send_edge(1'b1, 1'b1);
    repeat (8) @(negedge clk);
    chk(strb_cnt == 0, "R7", "no strobe without left word", 48'(strb_cnt), 48'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule